// File: doc/BRIEF.md
# Frame-Atomic Multichannel FIFO Writer

This block takes one sample from each of several acquisition channels, five by default, every time an acquisition strobe arrives. It stores them in a synchronous FIFO as one frame, in channel order. The writer checks the free space at the moment of the strobe. It admits the frame only if every word of it fits, and otherwise drops the whole frame and counts the drop in a saturating counter. The FIFO therefore never holds a partial frame. A reader that always pops a multiple of the frame length sees channel 0 at the start of each group.

A level input from the host, the logging enable, gates admission. The host holds it low until its reader is running. Before it raises the enable, it can pulse a flush that empties the FIFO in one clock. The flush also aborts any frame that is part-way written, so no leftover words can shift the alignment. Each stored word carries a start-of-frame flag that marks channel 0. The read side is a valid/ready port that accepts one pop per clock.

Top module: `frame_atomic_fifo`

## Requirements
- R1: An admitted frame writes NCH words on consecutive clocks, starting in the strobe cycle. Channel 0, taken from ch_data_i[DW-1:0], goes first, and channel c comes from bits [c*DW +: DW]. Only the channel 0 word is read back with rd_sof_o = 1.
- R2: A strobe is admitted only if level_o <= DEPTH - NCH in the strobe cycle. Otherwise none of the frame's words is written, and the FIFO never overflows. An admission at exactly NCH free slots fills the FIFO to DEPTH.
- R3: While en_i is low, strobes write nothing and do not change the dropped-frame counter.
- R4: A strobe that arrives while a frame is still being written is ignored and is not counted as a drop.
- R5: rd_valid_o is high exactly when level_o is non-zero, and rd_data_o/rd_sof_o then show the oldest word. A clock with rd_valid_o and rd_ready_i both high removes that word, and words leave in the order they were written.
- R6: drop_cnt_o increments by one for each enabled, non-ignored strobe that R2 refuses. It saturates at 2^DROP_W - 1 and is not cleared by a flush.
- R7: A clock that both writes and pops leaves level_o unchanged.
- R8: flush_i empties the FIFO in one clock (level_o = 0 and rd_valid_o = 0 on the next cycle) and aborts a frame in progress. No further words of that frame are written. A strobe in the flush cycle is ignored.
- R9: After reset, level_o = 0, rd_valid_o = 0 and drop_cnt_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Logging enable from the host |
| strobe_i | input | 1 | Acquisition strobe, one clock per cycle |
| ch_data_i | input | NCH*DW | Channel samples, channel 0 in the low bits |
| flush_i | input | 1 | Empty the FIFO and abort the current frame |
| rd_ready_i | input | 1 | Reader accepts the presented word |
| rd_valid_o | output | 1 | A word is presented |
| rd_data_o | output | DW | Oldest stored word |
| rd_sof_o | output | 1 | Presented word is channel 0 of a frame |
| level_o | output | $clog2(DEPTH+1) | Number of stored words |
| drop_cnt_o | output | DROP_W | Saturating count of dropped frames |

## Verification
The assertions check the following on every cycle:
- no write happens into a full FIFO and no pop happens from an empty one;
- a write paired with a pop keeps the level;
- a flush always leaves the FIFO empty;
- a disabled strobe never starts a frame;
- the drop counter either steps by one or holds at saturation.

Only the bench scenarios can show the end-to-end properties:
- the channel order and start-of-frame flag of the words actually read back;
- that refused frames leave no trace in the data stream;
- that the exact-fit boundary admits a frame;
- that an aborted frame contributes no words after the flush.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int unsigned FW_DEPTH  = 20;
  localparam int unsigned FW_NCH    = 5;
  localparam int unsigned FW_DW     = 16;
  localparam int unsigned FW_DROP_W = 8;

  typedef enum logic {
    WR_IDLE  = 1'b0,
    WR_BURST = 1'b1
  } wr_state_e;
endpackage

// File: rtl/fw_storage.sv
module fw_storage #(
  parameter int unsigned DEPTH = fw_pkg::FW_DEPTH,
  parameter int unsigned DW    = fw_pkg::FW_DW,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          push_sof_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_sof_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW:0]   mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wptr_q] <= {push_sof_i, push_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i)  rptr_q <= ptr_inc(rptr_q);
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rptr_q][DW-1:0];
  assign rd_sof_o  = mem_q[rptr_q][DW];
  assign level_o   = level_q;
  assign empty_o   = (level_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (level_q < LW'(DEPTH)) || pop_i); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_q != '0); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_q == '0); // R8
  AST_OCC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i) |=> $stable(level_q)); // R7
endmodule

// File: rtl/fw_writer.sv
module fw_writer #(
  parameter int unsigned DEPTH = fw_pkg::FW_DEPTH,
  parameter int unsigned NCH   = fw_pkg::FW_NCH,
  parameter int unsigned DW    = fw_pkg::FW_DW,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic [NCH*DW-1:0] ch_data_i,
  input  logic              flush_i,
  input  logic [LW-1:0]     level_i,
  output logic              push_o,
  output logic              push_sof_o,
  output logic [DW-1:0]     push_data_o,
  output logic              skip_o
);
  import fw_pkg::*;

  localparam logic [LW-1:0] ROOM_MAX = LW'(DEPTH - NCH);
  localparam logic [IW-1:0] IDX_LAST = IW'(NCH - 1);

  wr_state_e                state_q;
  logic [IW-1:0]            idx_q;
  logic [NCH-1:0][DW-1:0]   lat_q;
  logic                     start, admit, busy;

  assign busy  = (state_q == WR_BURST);
  assign start = strobe_i && en_i && !busy && !flush_i;
  assign admit = start && (level_i <= ROOM_MAX);
  assign skip_o = start && !admit;

  assign push_o      = !flush_i && (admit || busy);
  assign push_sof_o  = !busy;
  assign push_data_o = busy ? lat_q[idx_q] : ch_data_i[DW-1:0];

  always_ff @(posedge clk_i) begin
    if (admit) lat_q <= ch_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      idx_q   <= '0;
    end else if (flush_i) begin
      state_q <= WR_IDLE;
      idx_q   <= '0;
    end else if (admit) begin
      state_q <= (NCH > 1) ? WR_BURST : WR_IDLE;
      idx_q   <= IW'(1);
    end else if (busy) begin
      if (idx_q == IDX_LAST) begin
        state_q <= WR_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !en_i) |=> state_q == WR_IDLE); // R3
  AST_FLUSH_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> state_q == WR_IDLE); // R8
  AST_FULL_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && level_i > ROOM_MAX && !busy) |-> !push_o); // R2
endmodule

// File: rtl/fw_drop_ctr.sv
module fw_drop_ctr #(
  parameter int unsigned W = fw_pkg::FW_DROP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_DROP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX) |=> cnt_q == MAX); // R6
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R6
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/frame_atomic_fifo.sv
module frame_atomic_fifo #(
  parameter int unsigned DEPTH  = fw_pkg::FW_DEPTH,
  parameter int unsigned NCH    = fw_pkg::FW_NCH,
  parameter int unsigned DW     = fw_pkg::FW_DW,
  parameter int unsigned DROP_W = fw_pkg::FW_DROP_W,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic [NCH*DW-1:0] ch_data_i,
  input  logic              flush_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_sof_o,
  output logic [LW-1:0]     level_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic          push, push_sof, pop, skip, empty;
  logic [DW-1:0] push_data;

  fw_writer #(.DEPTH(DEPTH), .NCH(NCH), .DW(DW)) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .strobe_i    (strobe_i),
    .ch_data_i   (ch_data_i),
    .flush_i     (flush_i),
    .level_i     (level_o),
    .push_o      (push),
    .push_sof_o  (push_sof),
    .push_data_o (push_data),
    .skip_o      (skip)
  );

  assign pop = rd_ready_i && !empty && !flush_i;

  fw_storage #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (push),
    .push_sof_i  (push_sof),
    .push_data_i (push_data),
    .pop_i       (pop),
    .rd_data_o   (rd_data_o),
    .rd_sof_o    (rd_sof_o),
    .level_o     (level_o),
    .empty_o     (empty)
  );

  fw_drop_ctr #(.W(DROP_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (skip),
    .cnt_o  (drop_cnt_o)
  );

  assign rd_valid_o = !empty;

  AST_VALID_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == (level_o != '0)); // R5
  AST_POP_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && !push && !flush_i) |=> level_o == $past(level_o) - 1'b1); // R5
endmodule

// File: tb/sim_frame_atomic_fifo.sv
module sim_frame_atomic_fifo;
  localparam int DEPTH = 20, NCH = 5, DW = 16, DROP_W = 3, LW = 5;
  localparam int DMAX = (1 << DROP_W) - 1;

  logic              clk = 0, rst_n = 0, en = 0, strobe = 0, flush = 0, rdy = 0;
  logic [NCH*DW-1:0] chd = '0;
  logic              vld, sof;
  logic [DW-1:0]     rdat;
  logic [LW-1:0]     lvl;
  logic [DROP_W-1:0] drop;

  int vec = 0, bad = 0, exp_drop = 0, exp_lvl = 0;
  logic [DW:0] q[$];

  always #2 clk = ~clk;

  frame_atomic_fifo #(.DEPTH(DEPTH), .NCH(NCH), .DW(DW), .DROP_W(DROP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .strobe_i(strobe), .ch_data_i(chd),
    .flush_i(flush), .rd_ready_i(rdy), .rd_valid_o(vld), .rd_data_o(rdat),
    .rd_sof_o(sof), .level_o(lvl), .drop_cnt_o(drop));

  task automatic check(string req, int act, int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(int f, int c);
    return DW'((f << 8) | c);
  endfunction

  task automatic load(int f);
    for (int c = 0; c < NCH; c++) chd[c*DW +: DW] = word(f, c);
  endtask

  task automatic enqueue(int f);
    for (int c = 0; c < NCH; c++) q.push_back({(c == 0), word(f, c)});
    exp_lvl += NCH;
  endtask

  // strobe one frame, wait for its burst to finish, check level and drops
  task automatic send(int f, bit admit);
    load(f);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
    repeat (NCH - 1) @(negedge clk);
    if (admit) enqueue(f);
    else if (en) exp_drop++;
    check(admit ? "R2 level after admit" : "R2/R3 level after refuse", lvl, exp_lvl);
    check("R6 drop count", drop, (exp_drop > DMAX) ? DMAX : exp_drop);
  endtask

  task automatic pop_n(int n);
    rdy = 1;
    for (int i = 0; i < n; i++) begin
      check("R5 valid", vld, 1);
      check("R5/R1 data order", rdat, q[0][DW-1:0]);
      check("R1 sof flag", sof, q[0][DW]);
      @(negedge clk);
      void'(q.pop_front());
      exp_lvl--;
    end
    rdy = 0;
    check("R5 level after pops", lvl, exp_lvl);
  endtask

  initial begin
    #(4 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset level", lvl, 0);
    check("R9 reset valid", vld, 0);
    check("R9 reset drops", drop, 0);

    send(0, 0); // R3: disabled, nothing written, no drop
    check("R3 valid stays low", vld, 0);

    en = 1;
    load(1);
    strobe = 1;
    for (int k = 1; k <= NCH; k++) begin
      @(negedge clk);
      strobe = 0;
      check("R1 one word per clock", lvl, k);
    end
    enqueue(1);

    // R4: second strobe inside a burst is ignored
    load(2);
    strobe = 1;
    @(negedge clk);
    load(99);
    @(negedge clk);
    strobe = 0;
    load(2);
    repeat (NCH - 2) @(negedge clk);
    enqueue(2);
    @(negedge clk);
    check("R4 ignored strobe adds nothing", lvl, exp_lvl);
    check("R4 ignored strobe not dropped", drop, 0);

    send(3, 1);
    send(4, 1);
    send(5, 0);             // full: R2 refuse, R6 count
    pop_n(3);               // level 17
    send(6, 0);             // 3 free < NCH: R2 refuse
    pop_n(2);               // level 15, exactly NCH free
    send(7, 1);             // R2 exact fit
    check("R2 exact fit reaches depth", lvl, DEPTH);
    pop_n(DEPTH);
    check("R5 empty after drain", vld, 0);

    // R7: push and pop together
    send(10, 1);
    load(11);
    strobe = 1;
    rdy = 1;
    enqueue(11);
    for (int k = 0; k < NCH; k++) begin
      check("R7 data while streaming", rdat, q[0][DW-1:0]);
      @(negedge clk);
      strobe = 0;
      void'(q.pop_front());
      check("R7 level held", lvl, NCH);
    end
    rdy = 0;
    exp_lvl = NCH;
    pop_n(NCH);

    // R8: flush mid-frame, with a strobe in the flush cycle
    send(12, 1);
    load(13);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
    @(negedge clk);
    flush = 1;
    strobe = 1;
    @(negedge clk);
    flush = 0;
    strobe = 0;
    q.delete();
    exp_lvl = 0;
    check("R8 flush empties", lvl, 0);
    check("R8 flush drops valid", vld, 0);
    repeat (NCH) @(negedge clk);
    check("R8 aborted frame writes nothing", lvl, 0);
    check("R8 strobe in flush ignored", drop, (exp_drop > DMAX) ? DMAX : exp_drop);
    send(14, 1);
    pop_n(NCH);

    // R6 saturation
    for (int f = 20; f < 24; f++) send(f, 1);
    for (int f = 24; f < 32; f++) send(f, 0);
    check("R6 saturated", drop, DMAX);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule